// File: doc/BRIEF.md
# Per-Core Compare Timer with Virtual Offset

The block is a single per-core timer. It compares a 64-bit compare value against a count that is broadcast to it. In virtual mode that count is the broadcast system count minus a programmable 64-bit offset. In physical mode it is the system count itself. Software sets the timer in one of two ways. It can write the absolute compare value as two 32-bit halves. It can also write a signed 32-bit relative value, which the block adds to the current effective count to form the compare value. Reading the relative view gives the remaining distance as a signed down-counter. That value goes negative once the deadline has passed.

A control register holds an enable bit, a mask bit and a read-only status bit. The block drives a level-sensitive interrupt that stays high while the timer is enabled, unmasked and firing. The only ways to drop it are to mask the timer, disable it, or reprogram the deadline past the count.

Top module: `cmp_timer`

## Requirements
- R1: After reset, the enable bit, the mask bit, the compare value and the offset all read 0, and `irq_o` is 0.
- R2: The firing condition is an unsigned 64-bit comparison: compare value <= effective count. The control status bit (bit 2 at address 0) reads 1 when the timer is enabled and the condition holds, even if the timer is masked.
- R3: While the enable bit (bit 0 at address 0) is 0, the status bit reads 0 and `irq_o` is 0.
- R4: `irq_o` is a registered output. It equals enable AND NOT mask (bit 1 at address 0) AND the firing condition, as these stood one clock edge earlier.
- R5: A write to address 2 replaces bits 31:0 of the compare value. A write to address 3 replaces bits 63:32. Reading these addresses returns the same halves.
- R6: A write to address 1 sets the compare value to the effective count in that cycle plus the written word, sign-extended to 64 bits.
- R7: A read of address 1 returns bits 31:0 of (compare value minus effective count). After the timer fires, this reads as a negative two's-complement value.
- R8: In virtual mode the effective count is the system count minus the offset. Address 4 holds offset bits 31:0 and address 5 holds bits 63:32. If the offset feature is absent, the offset reads 0 and ignores writes.
- R9: Once asserted, `irq_o` stays high while the count advances. It falls only after the timer is masked, disabled, or given a compare value above the count.
- R10: Addresses 6 and 7 read 0, and writes to them change nothing. The status bit ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sys_count_i | input | 64 | Broadcast system count |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address, for both read and write |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from `addr_i` |
| irq_o | output | 1 | Level-sensitive timer interrupt |

## Verification
The assertions assume a few things about the inputs. `addr_i` and `wdata_i` hold steady around each write strobe. The system count changes only between clock edges. Compare-value stability is judged only in cycles without a write. The directed stimulus changes every input just after a falling edge and never issues two writes in the same cycle. It also moves the count by explicit jumps, including jumps that wrap past the 32-bit boundary. This lets the bench predict each compare value from the count it drove.

// File: rtl/ctmr_pkg.sv
package ctmr_pkg;
  localparam int CNT_W  = 64;
  localparam int REG_W  = 32;
  localparam int ADDR_W = 3;

  localparam int CTL_EN   = 0;
  localparam int CTL_MASK = 1;
  localparam int CTL_STAT = 2;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL   = 3'd0,
    A_REL    = 3'd1,
    A_CMP_LO = 3'd2,
    A_CMP_HI = 3'd3,
    A_OFS_LO = 3'd4,
    A_OFS_HI = 3'd5
  } ctmr_addr_e;

  function automatic logic [CNT_W-1:0] rel_to_abs(input logic [CNT_W-1:0] cnt,
                                                  input logic [REG_W-1:0] rel);
    logic [CNT_W-1:0] ext;
    ext = {{(CNT_W-REG_W){rel[REG_W-1]}}, rel};
    return cnt + ext;
  endfunction

  function automatic logic [REG_W-1:0] abs_to_rel(input logic [CNT_W-1:0] cval,
                                                  input logic [CNT_W-1:0] cnt);
    logic [CNT_W-1:0] diff;
    diff = cval - cnt;
    return diff[REG_W-1:0];
  endfunction

  function automatic logic [CNT_W-1:0] virt_count(input logic [CNT_W-1:0] phys,
                                                  input logic [CNT_W-1:0] ofs);
    return phys - ofs;
  endfunction

  function automatic logic has_fired(input logic [CNT_W-1:0] cval,
                                     input logic [CNT_W-1:0] cnt);
    return cval <= cnt;
  endfunction
endpackage

// File: rtl/ctmr_regs.sv
module ctmr_regs
  import ctmr_pkg::*;
#(
  parameter bit HAS_OFS = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  input  logic [CNT_W-1:0]  cnt_eff,
  output logic              en,
  output logic              mask,
  output logic [CNT_W-1:0]  cval,
  output logic [CNT_W-1:0]  ofs
);
  localparam int HI_W = CNT_W - REG_W;

  logic wr_ctrl, wr_rel, wr_lo, wr_hi;
  assign wr_ctrl = wr_en && (addr == A_CTRL);
  assign wr_rel  = wr_en && (addr == A_REL);
  assign wr_lo   = wr_en && (addr == A_CMP_LO);
  assign wr_hi   = wr_en && (addr == A_CMP_HI);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en   <= 1'b0;
      mask <= 1'b0;
    end else if (wr_ctrl) begin
      en   <= wdata[CTL_EN];
      mask <= wdata[CTL_MASK];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cval <= '0;
    end else if (wr_rel) begin
      cval <= rel_to_abs(cnt_eff, wdata);
    end else if (wr_lo) begin
      cval[REG_W-1:0] <= wdata;
    end else if (wr_hi) begin
      cval[CNT_W-1:REG_W] <= wdata[HI_W-1:0];
    end
  end

  generate
    if (HAS_OFS) begin : g_ofs
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          ofs <= '0;
        end else if (wr_en && addr == A_OFS_LO) begin
          ofs[REG_W-1:0] <= wdata;
        end else if (wr_en && addr == A_OFS_HI) begin
          ofs[CNT_W-1:REG_W] <= wdata[HI_W-1:0];
        end
      end
    end else begin : g_no_ofs
      assign ofs = '0;
    end
  endgenerate
endmodule

// File: rtl/ctmr_cmp.sv
module ctmr_cmp
  import ctmr_pkg::*;
#(
  parameter bit VIRT = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] phys,
  input  logic [CNT_W-1:0] ofs,
  input  logic [CNT_W-1:0] cval,
  input  logic             en,
  input  logic             mask,
  output logic [CNT_W-1:0] cnt_eff,
  output logic             fire,
  output logic             istat,
  output logic             irq
);
  generate
    if (VIRT) begin : g_virt
      assign cnt_eff = virt_count(phys, ofs);
    end else begin : g_phys
      logic [CNT_W-1:0] ofs_unused;
      assign ofs_unused = ofs;
      assign cnt_eff    = phys;
    end
  endgenerate

  assign fire  = has_fired(cval, cnt_eff);
  assign istat = en && fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= istat && !mask;
  end
endmodule

// File: rtl/ctmr_rdmux.sv
module ctmr_rdmux
  import ctmr_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic              en,
  input  logic              mask,
  input  logic              istat,
  input  logic [CNT_W-1:0]  cval,
  input  logic [CNT_W-1:0]  cnt_eff,
  input  logic [CNT_W-1:0]  ofs,
  output logic [REG_W-1:0]  rdata
);
  localparam int HI_W = CNT_W - REG_W;

  always_comb begin
    rdata = '0;
    case (addr)
      A_CTRL: begin
        rdata[CTL_EN]   = en;
        rdata[CTL_MASK] = mask;
        rdata[CTL_STAT] = istat;
      end
      A_REL:    rdata = abs_to_rel(cval, cnt_eff);
      A_CMP_LO: rdata = cval[REG_W-1:0];
      A_CMP_HI: rdata[HI_W-1:0] = cval[CNT_W-1:REG_W];
      A_OFS_LO: rdata = ofs[REG_W-1:0];
      A_OFS_HI: rdata[HI_W-1:0] = ofs[CNT_W-1:REG_W];
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
  import ctmr_pkg::*;
#(
  parameter bit VIRT_MODE   = 1'b1,
  parameter bit OFS_PRESENT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  sys_count_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  output logic              irq_o
);
  localparam bit HAS_OFS = VIRT_MODE && OFS_PRESENT;

  logic             en_w, mask_w, fire_w, istat_w;
  logic [CNT_W-1:0] cval_w, ofs_w, cnt_eff_w;

  ctmr_regs #(.HAS_OFS(HAS_OFS)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en_i), .addr(addr_i), .wdata(wdata_i),
    .cnt_eff(cnt_eff_w), .en(en_w), .mask(mask_w), .cval(cval_w), .ofs(ofs_w)
  );

  ctmr_cmp #(.VIRT(VIRT_MODE)) cmp_i (
    .clk(clk), .rst_n(rst_n), .phys(sys_count_i), .ofs(ofs_w), .cval(cval_w),
    .en(en_w), .mask(mask_w), .cnt_eff(cnt_eff_w), .fire(fire_w),
    .istat(istat_w), .irq(irq_o)
  );

  ctmr_rdmux rdmux_i (
    .addr(addr_i), .en(en_w), .mask(mask_w), .istat(istat_w), .cval(cval_w),
    .cnt_eff(cnt_eff_w), .ofs(ofs_w), .rdata(rdata_o)
  );
endmodule

// File: rtl/ctmr_chk.sv
module ctmr_chk
  import ctmr_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [REG_W-1:0]  wdata_i,
  input logic [REG_W-1:0]  rdata_o,
  input logic              irq_o,
  input logic              en_w,
  input logic              mask_w,
  input logic              fire_w,
  input logic [CNT_W-1:0]  cval_w,
  input logic [CNT_W-1:0]  cnt_eff_w
);
  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past(en_w)); // R4
  AST_IRQ_NEEDS_UNMASK: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> !$past(mask_w)); // R4
  AST_IRQ_LEVEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && en_w && !mask_w && fire_w) |=> irq_o); // R9
  AST_STAT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_i == A_CTRL && !en_w) |-> !rdata_o[CTL_STAT]); // R3
  AST_REL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && addr_i == A_REL) |=>
      cval_w == rel_to_abs($past(cnt_eff_w), $past(wdata_i))); // R6
  AST_CMP_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_i |=> $stable(cval_w)); // R5
endmodule

bind cmp_timer ctmr_chk chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .addr_i(addr_i), .wdata_i(wdata_i),
  .rdata_o(rdata_o), .irq_o(irq_o), .en_w(en_w), .mask_w(mask_w), .fire_w(fire_w),
  .cval_w(cval_w), .cnt_eff_w(cnt_eff_w)
);

// File: tb/cmp_timer_tb_top.sv
module cmp_timer_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] sys_count = '0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int          n_checks = 0;
  int          n_errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmp_timer dut_i (
    .clk(clk), .rst_n(rst_n), .sys_count_i(sys_count), .wr_en_i(wr_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic set_count(input logic [63:0] c);
    @(negedge clk);
    sys_count = c;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(3'd0, d); check("R1 ctrl", d, 0);
    check("R3 status off at reset", d[2], 0);
    rd(3'd2, d); check("R1 cmp lo", d, 0);
    rd(3'd3, d); check("R1 cmp hi", d, 0);
    rd(3'd4, d); check("R1 ofs lo", d, 0);
    check("R1 irq", irq, 0);
  endtask

  task automatic t_absolute;
    logic [31:0] d;
    set_count(64'd1000);
    wr(3'd2, 32'd1010);
    wr(3'd3, 32'd0);
    wr(3'd0, 32'h1);
    rd(3'd2, d); check("R5 cmp lo readback", d, 1010);
    rd(3'd0, d); check("R2 status before deadline", d, 32'h1);
    @(negedge clk); check("R4 irq before deadline", irq, 0);
    set_count(64'd1010);
    rd(3'd0, d); check("R2 status at deadline", d, 32'h5);
    check("R4 irq not yet registered", irq, 0);
    @(negedge clk); check("R4 irq one edge later", irq, 1);
  endtask

  task automatic t_level;
    logic [31:0] d;
    for (int i = 1; i <= 3; i++) begin
      set_count(64'd1010 + 64'(i * 7));
      check("R9 irq held while counting", irq, 1);
    end
    wr(3'd0, 32'h3);
    rd(3'd0, d); check("R2 status while masked", d, 32'h7);
    @(negedge clk); check("R9 mask drops irq", irq, 0);
    wr(3'd0, 32'h1);
    @(negedge clk); check("R4 unmask restores irq", irq, 1);
    wr(3'd0, 32'h0);
    rd(3'd0, d); check("R3 status with enable off", d, 0);
    @(negedge clk); check("R3 irq with enable off", irq, 0);
    wr(3'd0, 32'h1);
    @(negedge clk); check("R9 irq back on", irq, 1);
    wr(3'd3, 32'h1);
    rd(3'd3, d); check("R5 cmp hi readback", d, 1);
    @(negedge clk); check("R9 new compare drops irq", irq, 0);
    set_count(64'h0000_0001_0000_03F2);
    @(negedge clk); check("R2 fires after high half reached", irq, 1);
  endtask

  task automatic t_unsigned;
    logic [31:0] d;
    wr(3'd2, 32'h0);
    wr(3'd3, 32'h8000_0000);
    set_count(64'h7FFF_FFFF_FFFF_FFFF);
    rd(3'd0, d); check("R2 unsigned no fire", d[2], 0);
    set_count(64'hFFFF_FFFF_FFFF_FFF0);
    rd(3'd0, d); check("R2 unsigned fire", d[2], 1);
  endtask

  task automatic t_relative;
    logic [31:0] d;
    set_count(64'd5000);
    wr(3'd1, 32'd100);
    rd(3'd2, d); check("R6 rel write lo", d, 5100);
    rd(3'd3, d); check("R6 rel write hi", d, 0);
    rd(3'd1, d); check("R7 rel read positive", d, 100);
    set_count(64'd5150);
    rd(3'd1, d); check("R7 rel read negative", d, 32'hFFFF_FFCE);
    set_count(64'h0000_0001_0000_0005);
    wr(3'd1, 32'hFFFF_FFF6);
    rd(3'd2, d); check("R6 sign-extended lo", d, 32'hFFFF_FFFB);
    rd(3'd3, d); check("R6 sign-extended hi", d, 0);
    rd(3'd0, d); check("R2 negative rel fires", d[2], 1);
  endtask

  task automatic t_virtual;
    logic [31:0] d;
    wr(3'd4, 32'd1000);
    wr(3'd5, 32'd0);
    rd(3'd4, d); check("R8 ofs readback", d, 1000);
    set_count(64'd3000);
    wr(3'd1, 32'd50);
    rd(3'd2, d); check("R8 rel uses virtual count", d, 2050);
    set_count(64'd3040);
    rd(3'd1, d); check("R8 rel read on virtual count", d, 10);
    set_count(64'd3049);
    @(negedge clk); check("R8 no irq before virtual deadline", irq, 0);
    set_count(64'd3050);
    @(negedge clk); check("R8 irq at virtual deadline", irq, 1);
  endtask

  task automatic t_unmapped;
    logic [31:0] d;
    wr(3'd6, 32'hFFFF_FFFF);
    wr(3'd7, 32'hFFFF_FFFF);
    rd(3'd6, d); check("R10 addr 6 reads 0", d, 0);
    rd(3'd7, d); check("R10 addr 7 reads 0", d, 0);
    rd(3'd2, d); check("R10 cmp untouched", d, 2050);
    rd(3'd0, d); check("R10 ctrl untouched", d, 32'h5);
    wr(3'd0, 32'h4);
    rd(3'd0, d); check("R10 status not writable", d, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_errors++;
    n_checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_absolute();
    t_level();
    t_unsigned();
    t_relative();
    t_virtual();
    t_unmapped();
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end
endmodule